// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core (MIPS-style subset)

This block is a small 32-bit processor that completes one instruction per clock. In each cycle it presents the program counter to an instruction-memory read port and decodes the returned word using the fixed MIPS field layout. It reads two source registers, forms an ALU or address result and, when needed, drives a data-memory port. On the next rising edge it commits the register write and the new program counter together.

Both memories are outside the core and answer combinationally. Instruction and data ports are separate, so a fetch and a load or store happen in the same cycle. All data accesses are whole 32-bit words. Memory is byte addressed and big-endian, so a word access needs no byte swapping. The core passes the full 32-bit byte address to the data port.

Top module: `mips_core`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), the program counter and all 32 registers are cleared to zero. The first fetch after reset is at address 0.
- R2: Register 0 always reads as zero, and any write aimed at it is dropped.
- R3: Opcode is bits 31:26, rs is 25:21, rt is 20:16 and imm is 15:0. LW (opcode 0x23) loads the word at rs + sign-extended imm into rt. SW (0x2B) drives that address, asserts `dmem_we` and writes rt.
- R4: ADDIU (0x09) writes rs + sign-extended imm into rt.
- R5: Opcode 0x00 is the R-type group, with rd at 15:11, shamt at 10:6 and funct at 5:0. ADDU (funct 0x21) writes rs + rt into rd. SLL (funct 0x00) writes rt shifted left by shamt into rd.
- R6: BEQ (0x04) branches when rs equals rt. BLEZ (0x06) branches when rs, read as signed, is zero or negative. A taken branch goes to PC+4 + (sign-extended imm << 2); otherwise execution continues at PC+4. Neither form writes a register or memory.
- R7: J (0x02) and JAL (0x03) go to {PC+4 bits 31:28, target bits 25:0, 2'b00}. JAL also writes PC+4 into register 31.
- R8: JR (funct 0x08) jumps to the value of rs. JALR (funct 0x09) does the same and also writes PC+4 into rd.
- R9: Any other opcode, or any other funct under opcode 0x00, is illegal. It writes neither a register nor memory, and the PC advances by 4.
- R10: The instruction fetch and a load or store are served in the same cycle. The register writeback and the PC update take effect on the same rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched (the PC) |
| imem_data | input | 32 | Instruction word returned combinationally |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled by memory on the rising edge |
| dmem_rdata | input | 32 | Load data returned combinationally |

## Verification
The case of interest is a load or store that executes in the same cycle as an instruction fetch. Another case is a register writeback committed on the same edge as a branch or jump redirect, as with JAL and JALR. Directed code provokes these with a load that reads a word stored one cycle earlier, and with link-and-jump sequences whose saved return address is stored and then used as a jump target. Constrained random programs mix all the instruction classes. In every cycle, the bench compares the fetch address and the data-port outputs against an instruction-level model that it builds from the requirements. Register contents become visible through later stores, so a wrong write or a late PC update shows up as a mismatched address or store value.

// File: rtl/mips_core.sv
module mips_core (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_JAL   = 6'h03;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BLEZ  = 6'h06;
  localparam logic [5:0] OP_ADDIU = 6'h09;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] FN_SLL   = 6'h00;
  localparam logic [5:0] FN_JR    = 6'h08;
  localparam logic [5:0] FN_JALR  = 6'h09;
  localparam logic [5:0] FN_ADDU  = 6'h21;

  logic [31:0] pc;
  logic [31:0] rf [32];

  wire [5:0]  op    = imem_data[31:26];
  wire [4:0]  rs    = imem_data[25:21];
  wire [4:0]  rt    = imem_data[20:16];
  wire [4:0]  rd    = imem_data[15:11];
  wire [4:0]  shamt = imem_data[10:6];
  wire [5:0]  funct = imem_data[5:0];
  wire [31:0] simm  = {{16{imem_data[15]}}, imem_data[15:0]};
  wire [31:0] pc4   = pc + 32'd4;

  wire [31:0] va = (rs == 5'd0) ? 32'd0 : rf[rs];
  wire [31:0] vb = (rt == 5'd0) ? 32'd0 : rf[rt];
  wire [31:0] ea = va + simm;

  logic        wen;
  logic [4:0]  wdst;
  logic [31:0] wval;
  logic [31:0] npc;
  logic        mwe;
  logic        illegal;
  logic        is_branch;

  always_comb begin
    wen       = 1'b0;
    wdst      = rt;
    wval      = 32'd0;
    npc       = pc4;
    mwe       = 1'b0;
    illegal   = 1'b0;
    is_branch = 1'b0;
    case (op)
      OP_LW: begin
        wen  = 1'b1;
        wval = dmem_rdata;
      end
      OP_SW:    mwe = 1'b1;
      OP_ADDIU: begin
        wen  = 1'b1;
        wval = ea;
      end
      OP_BEQ: begin
        is_branch = 1'b1;
        if (va == vb) npc = pc4 + {simm[29:0], 2'b00};
      end
      OP_BLEZ: begin
        is_branch = 1'b1;
        if ($signed(va) <= 0) npc = pc4 + {simm[29:0], 2'b00};
      end
      OP_J:   npc = {pc4[31:28], imem_data[25:0], 2'b00};
      OP_JAL: begin
        npc  = {pc4[31:28], imem_data[25:0], 2'b00};
        wen  = 1'b1;
        wdst = 5'd31;
        wval = pc4;
      end
      OP_RTYPE: begin
        wdst = rd;
        case (funct)
          FN_SLL: begin
            wen  = 1'b1;
            wval = vb << shamt;
          end
          FN_ADDU: begin
            wen  = 1'b1;
            wval = va + vb;
          end
          FN_JR:   npc = va;
          FN_JALR: begin
            npc  = va;
            wen  = 1'b1;
            wval = pc4;
          end
          default: illegal = 1'b1;
        endcase
      end
      default: illegal = 1'b1;
    endcase
  end

  assign imem_addr  = pc;
  assign dmem_addr  = ea;
  assign dmem_wdata = vb;
  assign dmem_we    = mwe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= 32'd0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else begin
      pc <= npc;
      if (wen && wdst != 5'd0) rf[wdst] <= wval;
    end
  end

  a_r1_first_fetch_zero: assert property (@(posedge clk)
    $rose(rst_n) |-> imem_addr == 32'd0);

  a_r2_reg0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rf[0] == 32'd0);

  a_r9_illegal_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !dmem_we);

  a_r9_illegal_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> imem_addr == $past(imem_addr) + 32'd4);

  a_r6_branch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    is_branch |-> !dmem_we && !wen);

  a_r10_store_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> imem_addr == $past(imem_addr) + 32'd4);
endmodule

// File: tb/test_mips_core.sv
module test_mips_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  int errors = 0;
  int checks = 0;

  logic [31:0] prog [256];
  logic [31:0] mem [logic [31:0]];

  logic [31:0] mregs [32];
  string       wtag [32];
  logic [31:0] mpc;
  string       ptag;

  always #(CLK_PERIOD/2) clk = ~clk;

  mips_core i_mips_core (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem.exists(a[31:2])) return mem[a[31:2]];
    return {a[29:0], 2'b00} ^ 32'h5A3C_91E7;
  endfunction

  assign imem_data  = prog[imem_addr[9:2]];
  assign dmem_rdata = mem_rd(dmem_addr);

  always @(posedge clk) if (rst_n && dmem_we) mem[dmem_addr[31:2]] = dmem_wdata;

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [4:0] sh,
                                        input logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] t);
    return {op, t};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    mpc  = 32'd0;
    ptag = "R1";
    for (int i = 0; i < 32; i++) begin
      mregs[i] = 32'd0;
      wtag[i]  = (i == 0) ? "R2" : "R1";
    end
  endtask

  task automatic step();
    logic [31:0] ins, a, b, sx, pc4, npc, wv, maddr;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, wd;
    logic        wen, mwe, isls;
    string       ntag;
    ins  = prog[mpc[9:2]];
    op   = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
    a    = mregs[rs]; b = mregs[rt];
    sx   = {{16{ins[15]}}, ins[15:0]};
    pc4  = mpc + 32'd4;
    npc  = pc4; wen = 1'b0; wd = rt; wv = 32'd0; mwe = 1'b0; isls = 1'b0;
    maddr = a + sx; ntag = "R9";
    case (op)
      6'h23: begin isls = 1'b1; wen = 1'b1; wv = mem_rd(maddr); ntag = "R3"; end
      6'h2B: begin isls = 1'b1; mwe = 1'b1; ntag = "R3"; end
      6'h09: begin wen = 1'b1; wv = maddr; ntag = "R4"; end
      6'h04: begin ntag = "R6"; if (a == b) npc = pc4 + (sx << 2); end
      6'h06: begin ntag = "R6"; if ($signed(a) <= 0) npc = pc4 + (sx << 2); end
      6'h02: begin ntag = "R7"; npc = {pc4[31:28], ins[25:0], 2'b00}; end
      6'h03: begin ntag = "R7"; npc = {pc4[31:28], ins[25:0], 2'b00};
                   wen = 1'b1; wd = 5'd31; wv = pc4; end
      6'h00: begin
        wd = rd;
        case (fn)
          6'h00: begin ntag = "R5"; wen = 1'b1; wv = b << ins[10:6]; end
          6'h21: begin ntag = "R5"; wen = 1'b1; wv = a + b; end
          6'h08: begin ntag = "R8"; npc = a; end
          6'h09: begin ntag = "R8"; npc = a; wen = 1'b1; wv = pc4; end
          default: ntag = "R9";
        endcase
      end
      default: ntag = "R9";
    endcase
    chk(ptag, "fetch address", imem_addr, mpc);
    chk((ntag == "R9") ? "R9" : "R3", "store strobe", {31'd0, dmem_we}, {31'd0, mwe});
    if (mwe) chk(wtag[rt], "store data", dmem_wdata, b);
    if (isls) begin
      chk("R3", "data address", dmem_addr, maddr);
      chk("R10", "fetch during data access", imem_addr, mpc);
    end
    if (wen && wd != 5'd0) begin
      mregs[wd] = wv;
      wtag[wd]  = (op == 6'h00 && fn == 6'h09) ? "R8" : (op == 6'h03 ? "R7" : ntag);
    end
    mpc  = npc;
    ptag = (ntag == "R3") ? "R10" : ntag;
  endtask

  function automatic logic [4:0] rreg();
    return ($urandom % 8 == 0) ? 5'd31 : 5'($urandom % 8);
  endfunction

  function automatic logic [31:0] rand_instr();
    int k = $urandom % 13;
    logic [15:0] imm = 16'($urandom);
    logic [15:0] off = 16'($signed(int'($urandom % 9)) - 4);
    case (k)
      0, 1: return enc_i(6'h23, rreg(), rreg(), imm);
      2, 3: return enc_i(6'h2B, rreg(), rreg(), imm);
      4:    return enc_i(6'h09, rreg(), rreg(), imm);
      5:    return enc_r(rreg(), rreg(), rreg(), 5'($urandom), 6'h00);
      6:    return enc_r(rreg(), rreg(), rreg(), 5'd0, 6'h21);
      7:    return enc_i(6'h04, rreg(), rreg(), off);
      8:    return enc_i(6'h06, rreg(), 5'd0, off);
      9:    return enc_j(($urandom % 2) ? 6'h03 : 6'h02, 26'($urandom % 256));
      10:   return enc_r(rreg(), 5'd0, rreg(), 5'd0, ($urandom % 2) ? 6'h09 : 6'h08);
      11:   return enc_r(rreg(), rreg(), rreg(), 5'd0, 6'h2A);
      default: return enc_j(6'h3F, 26'($urandom));
    endcase
  endfunction

  task automatic run_from_reset(input int cycles);
    rst_n = 1'b0;
    mem.delete();
    repeat (2) @(negedge clk);
    chk("R1", "fetch address in reset", imem_addr, 32'd0);
    chk("R1", "store strobe in reset", {31'd0, dmem_we}, 32'd0);
    rst_n = 1'b1;
    model_reset();
    step();
    for (int c = 1; c < cycles; c++) begin
      @(negedge clk);
      step();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) prog[i] = enc_j(6'h3F, 26'd0);
    prog[0]  = enc_i(6'h09, 5'd0, 5'd1, 16'hFFFC);
    prog[1]  = enc_i(6'h09, 5'd1, 5'd0, 16'd5);
    prog[2]  = enc_i(6'h2B, 5'd0, 5'd0, 16'd8);
    prog[3]  = enc_i(6'h2B, 5'd0, 5'd1, 16'd16);
    prog[4]  = enc_i(6'h23, 5'd1, 5'd2, 16'd20);
    prog[5]  = enc_r(5'd0, 5'd2, 5'd3, 5'd4, 6'h00);
    prog[6]  = enc_r(5'd3, 5'd1, 5'd4, 5'd0, 6'h21);
    prog[7]  = enc_i(6'h2B, 5'd0, 5'd4, 16'd0);
    prog[8]  = enc_r(5'd1, 5'd1, 5'd7, 5'd0, 6'h3B);
    prog[9]  = enc_i(6'h04, 5'd1, 5'd2, 16'd2);
    prog[12] = enc_i(6'h06, 5'd1, 5'd0, 16'd1);
    prog[14] = enc_j(6'h03, 26'd20);
    prog[20] = enc_i(6'h2B, 5'd0, 5'd31, 16'd4);
    prog[21] = enc_r(5'd31, 5'd0, 5'd5, 5'd0, 6'h09);
    prog[15] = enc_i(6'h2B, 5'd0, 5'd5, 16'd12);
    prog[16] = enc_i(6'h04, 5'd0, 5'd1, 16'd40);
    prog[17] = enc_i(6'h09, 5'd0, 5'd6, 16'd100);
    prog[18] = enc_r(5'd6, 5'd0, 5'd0, 5'd0, 6'h08);
    prog[25] = enc_i(6'h2B, 5'd0, 5'd7, 16'd24);
    prog[26] = enc_i(6'h23, 5'd0, 5'd6, 16'd4);
    prog[27] = enc_i(6'h2B, 5'd0, 5'd6, 16'd28);
    prog[28] = enc_j(6'h02, 26'd28);
    run_from_reset(40);

    for (int i = 0; i < 256; i++) prog[i] = rand_instr();
    run_from_reset(4000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule